// File: doc/BRIEF.md
# Seconds Watchdog with Fixed-Width Reset Pulse

This block is a seconds-granular watchdog that sits in the register space of a clock generator. Software sees one 8-bit register. It holds an arm bit, a read-only expiry flag and a 6-bit period in seconds. An internal prescaler divides the system clock into one-second ticks. While the watchdog is armed and has not expired, a down-counter loaded from the period counts those ticks.

When the count runs out, the block does three things. It raises the expiry flag. It emits a one-cycle strobe that tells the frequency-selection logic to drop any software-chosen setting and go back to the latched hardware strap setting. In the next cycle it begins a reset pulse of fixed length, nominally 4 ms. The reset line is modelled the open-drain way: a constant low data value plus an output enable that is active for the length of the pulse. After expiry the timer stays idle until software disarms it and arms it again. Each write that arms the timer reloads the period and restarts the one-second phase.

Top module: `wdt_pulse_guard`

## Requirements
- R1: After reset, rd_data reads 0x00, rst_oe and freq_revert are 0, and rst_do is 0.
- R2: rd_data bit 7 returns the last written arm bit and bits 5:0 return the last written period. Bit 6 is the expiry flag, and a write to bit 6 has no effect on it.
- R3: A write with bit 7 = 1 and period N (1..63) while the flag is clear causes expiry exactly N*TICK_CYCLES clock cycles after that write. At that point rd_data bit 6 reads 1.
- R4: A period of 0 written with bit 7 = 1 expires after a single tick, that is TICK_CYCLES cycles after the write.
- R5: A write with bit 7 = 1 while the timer is counting reloads the period and restarts timing, so expiry falls N*TICK_CYCLES cycles after the latest write.
- R6: A write with bit 7 = 0 stops the timer, so no expiry occurs while disarmed. The same write clears the expiry flag in the following cycle.
- R7: freq_revert is high for exactly one cycle per expiry, in the same cycle the flag first reads 1.
- R8: rst_oe goes high in the cycle after the freq_revert strobe and stays high for exactly PULSE_CYCLES cycles. rst_do is always 0.
- R9: Once the flag is set, no further expiry occurs, even if bit 7 = 1 is written again. A write of bit 7 = 0 followed by a write of bit 7 = 1 re-arms the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_data | input | 8 | Write data: [7] arm, [6] ignored, [5:0] period in seconds |
| rd_data | output | 8 | Read data: [7] arm, [6] expiry flag, [5:0] period |
| freq_revert | output | 1 | One-cycle strobe forcing the frequency back to the strap setting |
| rst_oe | output | 1 | Reset line output enable, high while the reset pulse is driven |
| rst_do | output | 1 | Reset line data value, constant 0 |

## Verification
The hardest state to reach from the ports is the window just after expiry. There, the arm bit still reads 1 and the flag is set, yet a fresh arming write must not start a second countdown. The bench reaches it by letting a timeout complete and then writing bit 7 = 1 again. It waits several tick periods to confirm that no strobe or pulse appears, then disarms, re-arms, and measures a clean second expiry. A mid-count rewrite, issued after some ticks have already elapsed, checks that the prescaler phase restarts and does not carry over.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int unsigned REG_W  = 8;
   localparam int unsigned SECS_W = 6;

   typedef struct packed {
      logic              armed;
      logic              expired;
      logic [SECS_W-1:0] secs;
   } wdt_reg_t;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
   parameter int unsigned TICK_CYCLES = 125_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic tick
);
   localparam int unsigned PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

   generate
      if (TICK_CYCLES == 1) begin : g_every_cycle
         assign tick = run;
      end else begin : g_counter
         logic [PW-1:0] phase_q;
         logic          at_end;

         assign at_end = (phase_q == PW'(TICK_CYCLES - 1));
         assign tick   = run && at_end;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              phase_q <= '0;
            else if (restart || !run) phase_q <= '0;
            else if (at_end)         phase_q <= '0;
            else                     phase_q <= phase_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
   parameter int unsigned PULSE_CYCLES = 500_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic active
);
   localparam int unsigned QW = $clog2(PULSE_CYCLES + 1);

   logic [QW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_q <= '0;
      else if (fire)           left_q <= QW'(PULSE_CYCLES);
      else if (left_q != '0)   left_q <= left_q - 1'b1;
   end

   assign active = (left_q != '0);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
   import wdt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             tick,
   output logic             run,
   output wdt_reg_t         regs,
   output logic             expire
);
   wdt_reg_t          reg_q;
   logic [SECS_W-1:0] remain_q;
   logic              expire_q;
   logic              unused_ro_bit;

   assign unused_ro_bit = wr_data[SECS_W];
   assign run           = reg_q.armed && !reg_q.expired;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q    <= '0;
         remain_q <= '0;
         expire_q <= 1'b0;
      end else begin
         expire_q <= 1'b0;
         if (wr_en) begin
            reg_q.armed <= wr_data[REG_W-1];
            reg_q.secs  <= wr_data[SECS_W-1:0];
            remain_q    <= wr_data[SECS_W-1:0];
            if (!wr_data[REG_W-1]) reg_q.expired <= 1'b0;
         end else if (tick) begin
            if (remain_q <= SECS_W'(1)) begin
               reg_q.expired <= 1'b1;
               expire_q      <= 1'b1;
            end else begin
               remain_q <= remain_q - 1'b1;
            end
         end
      end
   end

   assign regs   = reg_q;
   assign expire = expire_q;
endmodule

// File: rtl/wdt_pulse_guard.sv
module wdt_pulse_guard
   import wdt_pkg::*;
#(
   parameter int unsigned TICK_CYCLES  = 125_000_000,
   parameter int unsigned PULSE_CYCLES = 500_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   output logic       freq_revert,
   output logic       rst_oe,
   output logic       rst_do
);
   generate
      if (TICK_CYCLES < 1) begin : g_bad_tick
         $error("TICK_CYCLES must be at least 1");
      end
      if (PULSE_CYCLES < 1) begin : g_bad_pulse
         $error("PULSE_CYCLES must be at least 1");
      end
   endgenerate

   logic     run;
   logic     tick;
   logic     expire;
   wdt_reg_t regs;

   wdt_prescale #(.TICK_CYCLES(TICK_CYCLES)) u_prescale (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (wr_en),
      .run     (run),
      .tick    (tick)
   );

   wdt_core u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .tick    (tick),
      .run     (run),
      .regs    (regs),
      .expire  (expire)
   );

   wdt_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .fire   (expire),
      .active (rst_oe)
   );

   assign rd_data     = regs;
   assign freq_revert = expire;
   assign rst_do      = 1'b0;
endmodule

// File: rtl/wdt_pulse_guard_chk.sv
module wdt_pulse_guard_chk #(
   parameter int unsigned PULSE_CYCLES = 500_000
) (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic wr_arm,
   input logic rd_arm,
   input logic rd_flag,
   input logic freq_revert,
   input logic rst_oe
);
   localparam int unsigned RW = $clog2(PULSE_CYCLES + 2);
   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      run_q <= '0;
      else if (rst_oe) run_q <= run_q + 1'b1;
      else             run_q <= '0;
   end

   p_flag_rise_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_flag) |-> freq_revert);
   p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      freq_revert |=> !freq_revert);
   p_pulse_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      freq_revert |=> rst_oe);
   p_pulse_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_oe |-> (run_q < RW'(PULSE_CYCLES)));
   p_disarm_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_arm) |=> !rd_flag);
   p_strobe_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      freq_revert |-> (rd_arm && rd_flag));
endmodule

bind wdt_pulse_guard wdt_pulse_guard_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_arm      (wr_data[7]),
   .rd_arm      (rd_data[7]),
   .rd_flag     (rd_data[6]),
   .freq_revert (freq_revert),
   .rst_oe      (rst_oe)
);

// File: tb/wdt_pulse_guard_tb_top.sv
module wdt_pulse_guard_tb_top;
   localparam int unsigned T  = 20;
   localparam int unsigned PW = 8;
   localparam int NV = 6;
   localparam logic [5:0] SECS_TBL [NV] = '{6'd1, 6'd2, 6'd3, 6'd0, 6'd4, 6'd7};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       freq_revert, rst_oe, rst_do;
   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   wdt_pulse_guard #(.TICK_CYCLES(T), .PULSE_CYCLES(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .freq_revert(freq_revert), .rst_oe(rst_oe), .rst_do(rst_do)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_revert(input int limit, output int c, output bit seen);
      c = 0;
      seen = 0;
      while (c < limit && !seen) begin
         @(negedge clk);
         c++;
         if (freq_revert) seen = 1;
      end
   endtask

   task automatic measure_pulse(output int n);
      n = 0;
      @(negedge clk);
      while (rst_oe && n < 1000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic run_all;
      int c, n, exp;
      bit seen;
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 rd_data", rd_data, 0);
      check("R1 rst_oe", rst_oe, 0);
      check("R1 revert", freq_revert, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rst_do", rst_do, 0);

      // table walk: R3 / R4 / R7 / R8
      for (int i = 0; i < NV; i++) begin
         exp = (SECS_TBL[i] == 0) ? T : SECS_TBL[i] * T;
         do_write({2'b10, SECS_TBL[i]});
         check("R2 readback", rd_data, {2'b10, SECS_TBL[i]});
         wait_revert(exp + 5, c, seen);
         if (SECS_TBL[i] == 0) check("R4 zero period expiry cycle", seen ? c : -1, exp);
         else                  check("R3 expiry cycle", seen ? c : -1, exp);
         check("R3 flag set", rd_data[6], 1);
         measure_pulse(n);
         check("R8 pulse length", n, PW);
         check("R8 rst_do", rst_do, 0);
         check("R7 single strobe", freq_revert, 0);
         do_write(8'h00);
         check("R6 flag cleared", rd_data, 0);
      end

      // R2: bit 6 write ignored
      do_write(8'h45);
      check("R2 ro flag bit", rd_data, 8'h05);

      // R5: rewrite mid-count reloads
      do_write(8'h83);
      repeat (2 * T + 7) @(negedge clk);
      check("R5 no early expiry", rd_data[6], 0);
      do_write(8'h82);
      wait_revert(4 * T, c, seen);
      check("R5 reload expiry cycle", seen ? c : -1, 2 * T);
      repeat (PW + 2) @(negedge clk);

      // R9: arm while flagged does nothing
      do_write(8'h81);
      check("R9 flag held", rd_data, 8'hC1);
      wait_revert(3 * T, c, seen);
      check("R9 no re-expiry", seen, 0);
      check("R9 no pulse", rst_oe, 0);
      do_write(8'h01);
      check("R6 disarm clears", rd_data, 8'h01);
      do_write(8'h81);
      wait_revert(2 * T, c, seen);
      check("R9 re-armed expiry", seen ? c : -1, T);
      repeat (PW + 2) @(negedge clk);

      // R6: disarm mid-count stops timer
      do_write(8'h00);
      do_write(8'h81);
      repeat (T / 2) @(negedge clk);
      do_write(8'h01);
      wait_revert(3 * T, c, seen);
      check("R6 disarmed no expiry", seen, 0);
      check("R6 disarmed readback", rd_data, 8'h01);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100_000) @(posedge clk);
            errors++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule